// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

This block is a single-port synchronous memory with 18-bit words. It sits next to a processor as the data store of a cache and answers every cycle with no wait states. The word is split into two 9-bit byte lanes. Each lane has its own write enable, and the ninth bit of a lane is stored and returned like any other data bit. The address width is a parameter. The default keeps the array small, and a value of 16 gives the full 64K-word array.

An access starts when either of two active-low address strobes is sampled low at a rising clock edge while chip select is low. One strobe belongs to the processor and the other to the cache controller. The address is captured at that edge. From then on, a wrapping 2-bit counter supplies the low two address bits. The counter steps only at edges where the active-low advance input is low. A build parameter fixes the step order to interleaved or linear. Read data is registered, so it appears on the shared bus one clock after the address is registered. The active-low output enable gates the bus drivers without waiting for a clock.

Write enables are captured at the same edge as the address. The data word is taken from the bus at the following edge. For the whole of that write cycle the block keeps its drivers off the bus.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, and until the first burst start, the block never drives `dq`, even with `oe_n` low.
- R2: A burst start registers `addr` at the edge where the start is sampled. The word at that address is driven on `dq` after the next rising edge, and not before it.
- R3: Either strobe (`proc_strb_n` or `ctrl_strb_n`) starts a burst on its own. Both strobes low in the same cycle act as a single start at the presented `addr`.
- R4: A strobe sampled while `cs_n` is high is ignored. The current burst address is unchanged, and the bus keeps returning the word it addressed before.
- R5: The burst address steps by one position at each edge where `adv_n` is low. It holds at edges where `adv_n` is high.
- R6: With the interleaved order, the low two address bits at burst step k equal the start value of `addr[1:0]` XOR k.
- R7: With the linear order, the low two address bits at burst step k equal the start value of `addr[1:0]` plus k, modulo 4.
- R8: After four steps the burst wraps back to its starting word. Address bits above bit 1 never change during a burst.
- R9: `wr_hi_n` low writes `dq[17:9]` and `wr_lo_n` low writes `dq[8:0]`. The data is taken at the edge after the enables were sampled, and a lane whose enable was high keeps its old contents.
- R10: With `oe_n` high, `dq` is released at once with no clock edge needed. Driving resumes as soon as `oe_n` returns low.
- R11: In the cycle after a write enable is sampled low, the block does not drive `dq`, whatever the state of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the burst and output state |
| addr | input | ADDR_W | Word address, captured at a burst start |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Cache-controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs_n | input | 1 | Chip select, sampled with the strobes, active low |
| wr_hi_n | input | 1 | Upper byte lane write enable, active low |
| wr_lo_n | input | 1 | Lower byte lane write enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | 2*LANE_W | Shared three-state data bus |

## Verification
The bench runs bursts from all four start offsets through an interleaved instance and a linear instance side by side. It runs five steps so that the wrap is observed. A swapped or mis-stepped order would return a neighbouring word at some step.

It targets the first-read latency right after reset, where an early or stale output shows up as a driven bus one cycle too soon. It also targets a strobe with chip select off, which a careless decoder would treat as a new burst. Single-lane writes are checked for a clobbered opposite lane. Write cycles and output enable are checked at the bus itself, where a missing high-impedance release would show as contention.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic {
      ORDER_INTERLEAVE = 1'b0,
      ORDER_LINEAR     = 1'b1
   } burst_order_e;

   localparam int unsigned SBS_LANES = 2;

endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
   import sbs_pkg::*;
#(
   parameter int unsigned  ADDR_W = 8,
   parameter burst_order_e ORDER  = ORDER_INTERLEAVE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic              step,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] cur_addr
);

   localparam int unsigned HI_W = ADDR_W - 2;

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   logic [1:0]        low_bits;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("sbs_burst_ctr: ADDR_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= 2'd0;
      end else if (ld) begin
         base_q <= addr;
         cnt_q  <= 2'd0;
      end else if (step) begin
         cnt_q  <= cnt_q + 2'd1;
      end
   end

   generate
      if (ORDER == ORDER_INTERLEAVE) begin : g_interleave
         assign low_bits = base_q[1:0] ^ cnt_q;
      end else begin : g_linear
         assign low_bits = base_q[1:0] + cnt_q;
      end
   endgenerate

   assign cur_addr = {base_q[ADDR_W-1:2], low_bits};

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cur_addr == $past(addr)));

   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && step) |=> (cnt_q == $past(cnt_q) + 2'd1));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !step) |=> $stable(cur_addr));

   p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> (cur_addr[ADDR_W-1 -: HI_W] == $past(cur_addr[ADDR_W-1 -: HI_W])));

endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   generate
      if (LANE_W == 0) begin : g_bad_lane
         $error("sbs_lane_mem: LANE_W must be non-zero");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we) begin
         mem[addr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         rdata <= mem[addr];
      end
   end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
   import sbs_pkg::*;
#(
   parameter int unsigned  ADDR_W = 8,
   parameter int unsigned  LANE_W = 9,
   parameter burst_order_e ORDER  = ORDER_INTERLEAVE
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  proc_strb_n,
   input  logic                  ctrl_strb_n,
   input  logic                  adv_n,
   input  logic                  cs_n,
   input  logic                  wr_hi_n,
   input  logic                  wr_lo_n,
   input  logic                  oe_n,
   inout  wire  [2*LANE_W-1:0]   dq
);

   localparam int unsigned WORD_W = SBS_LANES * LANE_W;

   logic                 strobe;
   logic                 ld;
   logic                 step;
   logic                 sel_now;
   logic                 active_q;
   logic                 sel_q;
   logic [SBS_LANES-1:0] wr_q;
   logic                 rd_vld_q;
   logic                 dq_drv;
   logic [ADDR_W-1:0]    cur_addr;
   logic [WORD_W-1:0]    rd_word;

   generate
      if (WORD_W != 2 * LANE_W) begin : g_bad_lanes
         $error("sync_burst_sram: lane count must be two");
      end
   endgenerate

   assign strobe  = !proc_strb_n || !ctrl_strb_n;
   assign ld      = strobe && !cs_n;
   assign step    = active_q && !ld && !adv_n;
   assign sel_now = ld || active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sel_q    <= 1'b0;
         wr_q     <= '0;
         rd_vld_q <= 1'b0;
      end else begin
         active_q <= active_q || ld;
         sel_q    <= sel_now;
         wr_q     <= sel_now ? {!wr_hi_n, !wr_lo_n} : '0;
         rd_vld_q <= sel_q && (wr_q == '0);
      end
   end

   sbs_burst_ctr #(
      .ADDR_W (ADDR_W),
      .ORDER  (ORDER)
   ) i_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld),
      .step     (step),
      .addr     (addr),
      .cur_addr (cur_addr)
   );

   generate
      for (genvar l = 0; l < SBS_LANES; l++) begin : g_lane
         sbs_lane_mem #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
         ) i_mem (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_q[l]),
            .addr  (cur_addr),
            .wdata (dq[l*LANE_W +: LANE_W]),
            .rdata (rd_word[l*LANE_W +: LANE_W])
         );
      end
   endgenerate

   assign dq_drv = !oe_n && rd_vld_q && (wr_q == '0);
   assign dq     = dq_drv ? rd_word : {WORD_W{1'bz}};

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> !dq_drv);

   p_ignore_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && cs_n) |=> ($stable(cur_addr) || $past(step)));

   p_write_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_now && (!wr_hi_n || !wr_lo_n)) |=> !dq_drv);

endmodule

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
   import sbs_pkg::*;

   localparam int CLK_PER = 8;
   localparam int AW      = 8;
   localparam int WW      = 18;

   localparam logic [7:0] VEC_ADDR [4] = '{8'h10, 8'h25, 8'h4A, 8'hB7};
   localparam logic [7:0] VEC_ILV  [4] = '{8'h1B, 8'h4E, 8'hB1, 8'hE4};
   localparam logic [7:0] VEC_LIN  [4] = '{8'h1B, 8'h6C, 8'hB1, 8'hC6};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          proc_strb_n = 1'b1;
   logic          ctrl_strb_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          cs_n = 1'b0;
   logic          wr_hi_n = 1'b1;
   logic          wr_lo_n = 1'b1;
   logic          oe_n = 1'b0;
   logic          tb_drv = 1'b0;
   logic [WW-1:0] tb_dat = '0;
   wire  [WW-1:0] dq_ilv;
   wire  [WW-1:0] dq_lin;

   int checks = 0;
   int errors = 0;

   localparam logic [WW-1:0] RELEASED = {WW{1'b1}};

   always #(CLK_PER/2) clk = ~clk;

   generate
      for (genvar b = 0; b < WW; b++) begin : g_pull
         pullup (dq_ilv[b]);
         pullup (dq_lin[b]);
      end
   endgenerate

   assign dq_ilv = tb_drv ? tb_dat : {WW{1'bz}};
   assign dq_lin = tb_drv ? tb_dat : {WW{1'bz}};

   sync_burst_sram #(.ADDR_W(AW), .LANE_W(9), .ORDER(ORDER_INTERLEAVE)) i_sync_burst_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strb_n(proc_strb_n),
      .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .cs_n(cs_n), .wr_hi_n(wr_hi_n),
      .wr_lo_n(wr_lo_n), .oe_n(oe_n), .dq(dq_ilv));

   sync_burst_sram #(.ADDR_W(AW), .LANE_W(9), .ORDER(ORDER_LINEAR)) i_sync_burst_sram_lin (
      .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strb_n(proc_strb_n),
      .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .cs_n(cs_n), .wr_hi_n(wr_hi_n),
      .wr_lo_n(wr_lo_n), .oe_n(oe_n), .dq(dq_lin));

   function automatic logic [WW-1:0] pat(input logic [7:0] a);
      return {2'b10, a, ~a};
   endfunction

   task automatic chk(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic write_word(input logic [7:0] a, input logic [WW-1:0] d,
                             input logic hi, input logic lo);
      @(negedge clk);
      addr = a; proc_strb_n = 1'b0; cs_n = 1'b0; adv_n = 1'b1;
      wr_hi_n = !hi; wr_lo_n = !lo;
      @(posedge clk);
      @(negedge clk);
      proc_strb_n = 1'b1; wr_hi_n = 1'b1; wr_lo_n = 1'b1;
      tb_drv = 1'b1; tb_dat = d;
      @(posedge clk);
      @(negedge clk);
      tb_drv = 1'b0;
   endtask

   task automatic read_word(input logic [7:0] a, input logic use_proc, input logic use_ctrl);
      @(negedge clk);
      addr = a; cs_n = 1'b0; adv_n = 1'b1; oe_n = 1'b0;
      proc_strb_n = !use_proc; ctrl_strb_n = !use_ctrl;
      @(posedge clk);
      @(negedge clk);
      proc_strb_n = 1'b1; ctrl_strb_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PER * 150000);
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset bus released", dq_ilv, RELEASED);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1 idle bus released", dq_lin, RELEASED);

      // R2: first read after reset, latency of one clock after address registration
      @(negedge clk);
      addr = 8'h77; proc_strb_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      proc_strb_n = 1'b1;
      chk("R2 no data before latency", dq_ilv, RELEASED);
      @(posedge clk);
      @(negedge clk);
      chk("R2 bus driven after latency", dq_ilv === RELEASED ? 18'h0 : 18'h1, 18'h1);

      // preload: every word written with both lanes (R9)
      for (int a = 0; a < 256; a++) begin
         write_word(a[7:0], pat(a[7:0]), 1'b1, 1'b1);
      end

      read_word(8'h77, 1'b1, 1'b0);
      chk("R2 read word", dq_ilv, pat(8'h77));
      chk("R9 full word write", dq_lin, pat(8'h77));

      // table walk: R6, R7, R8
      for (int v = 0; v < 4; v++) begin
         @(negedge clk);
         addr = VEC_ADDR[v]; proc_strb_n = 1'b0; adv_n = 1'b1;
         @(posedge clk);
         @(negedge clk);
         proc_strb_n = 1'b1; adv_n = 1'b0;
         for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R6 interleaved step", dq_ilv,
                pat({VEC_ADDR[v][7:2], VEC_ILV[v][7-2*(k%4) -: 2]}));
            chk("R7 linear step", dq_lin,
                pat({VEC_ADDR[v][7:2], VEC_LIN[v][7-2*(k%4) -: 2]}));
         end
         adv_n = 1'b1;
      end

      // R3: controller strobe alone, then both strobes together
      read_word(8'h5C, 1'b0, 1'b1);
      chk("R3 controller strobe", dq_ilv, pat(8'h5C));
      read_word(8'h9D, 1'b1, 1'b1);
      chk("R3 both strobes", dq_lin, pat(8'h9D));
      @(negedge clk);
      adv_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      adv_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R3 single start then step", dq_ilv, pat(8'h9C));

      // R4 and R5: deselected strobe ignored, address held without advance
      read_word(8'h50, 1'b1, 1'b0);
      @(negedge clk);
      addr = 8'h60; cs_n = 1'b1; proc_strb_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cs_n = 1'b0; proc_strb_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R4 deselected strobe ignored", dq_ilv, pat(8'h50));
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R5 hold without advance", dq_lin, pat(8'h50));

      // R9: single-lane writes
      write_word(8'h33, 18'h3FFFF, 1'b1, 1'b0);
      read_word(8'h33, 1'b1, 1'b0);
      chk("R9 upper lane only", dq_ilv, {9'h1FF, pat(8'h33)[8:0]});
      write_word(8'h34, 18'h00000, 1'b0, 1'b1);
      read_word(8'h34, 1'b1, 1'b0);
      chk("R9 lower lane only", dq_lin, {pat(8'h34)[17:9], 9'h000});

      // R10: asynchronous output enable
      read_word(8'h41, 1'b1, 1'b0);
      #1 oe_n = 1'b1;
      #1 chk("R10 oe release", dq_ilv, RELEASED);
      oe_n = 1'b0;
      #1 chk("R10 oe restore", dq_ilv, pat(8'h41));

      // R11: write cycle releases the bus even with oe_n low
      read_word(8'h42, 1'b1, 1'b0);
      chk("R11 bus driven before write", dq_ilv, pat(8'h42));
      @(negedge clk);
      addr = 8'hFF; proc_strb_n = 1'b0; wr_hi_n = 1'b0; wr_lo_n = 1'b0;
      @(posedge clk);
      #1 chk("R11 released in write cycle", dq_ilv, RELEASED);
      @(negedge clk);
      proc_strb_n = 1'b1; wr_hi_n = 1'b1; wr_lo_n = 1'b1;
      chk("R11 linear released in write cycle", dq_lin, RELEASED);
      @(posedge clk);
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule